// File: doc/BRIEF.md
# BMP Byte Stream Formatter

This block turns a stream of processed pixel pairs into the exact byte sequence of an uncompressed 24-bit BMP file. After reset it first emits a 54-byte file header. The header's size, width and height fields are derived from the image dimension parameters. It then serializes every incoming pixel pair into six bytes. Bytes leave one per beat on a valid/ready output, so a downstream sink can pace the stream with backpressure.

Each input beat carries two pixels of three bytes each. A pair is taken only after all six bytes of the previous pair have been handed off. A last-byte flag marks the final pixel byte of the file. A sticky done flag then reports that the whole file has gone out. A new header is produced only after another reset. The image width is expected to be a multiple of 4, so no row padding is inserted.

Top module: `bmp_stream_fmt`

## Requirements
- R1: Header bytes 0 and 1 are 66 and 77. Bytes 10..13 hold the pixel data offset 54, and bytes 14..17 hold the info block size 40, each as a 32-bit little-endian value.
- R2: Bytes 18..21 hold IMG_W and bytes 22..25 hold IMG_H as 32-bit little-endian values. Bytes 26..27 hold 1 and bytes 28..29 hold 24 as 16-bit little-endian values. Bytes 6..9 and 30..53 are 0.
- R3: Bytes 2..5 hold the file size 54 + 3*IMG_W*IMG_H as a 32-bit little-endian value.
- R4: While the 54 header bytes are being emitted, pair_ready stays low. Pixel bytes start at file byte 54.
- R5: An accepted pair produces exactly six output bytes, in the order pair_data[7:0], [15:8], [23:16], [31:24], [39:32], [47:40].
- R6: A new pair is accepted only after all six bytes of the previous pair have been handshaken. In the cycle after an accept, pair_ready is low.
- R7: While out_valid is high and out_ready is low, out_valid, out_byte and out_last hold their values into the next cycle.
- R8: out_last is high on exactly one handshaken byte, the final byte of the file (index 53 + 3*IMG_W*IMG_H).
- R9: After the final byte, file_done stays high and out_valid and pair_ready stay low. Further pair_valid is ignored and no more bytes appear.
- R10: During reset, file_done and pair_ready are low. After each reset the header is emitted again from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | Pixel pair offered |
| pair_data | input | 48 | Two pixels; byte j at bits [8j+7:8j] |
| pair_ready | output | 1 | Pair accepted when high with pair_valid |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Sink accepts the byte |
| out_byte | output | 8 | File byte |
| out_last | output | 1 | Final byte of the file |
| file_done | output | 1 | Whole file has been emitted |

## Verification
The assertions check the following on every cycle:
- stall stability;
- that the input stays closed through the header and right after each accept;
- that the last flag falls on the final byte count;
- that the done state is quiet and sticky.

Only the bench scenarios can show the header field values, the byte order within a pair and the total length. The bench checks these by capturing the whole file under irregular input gaps and output stalls. It also checks that the header is re-emitted after a second reset.

// File: rtl/bmp_stream_fmt.sv
module bmp_stream_fmt #(
  parameter int IMG_W = 768,
  parameter int IMG_H = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pair_valid,
  input  logic [47:0] pair_data,
  output logic        pair_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte,
  output logic        out_last,
  output logic        file_done
);
  localparam int NPAIRS = IMG_W * IMG_H / 2;
  localparam int FSIZE  = 54 + 3 * IMG_W * IMG_H;
  localparam int PW     = $clog2(NPAIRS + 1);

  typedef enum logic [1:0] {S_HDR, S_PIX, S_DONE} st_t;
  st_t st;
  logic [5:0]    hdr_idx;
  logic [PW-1:0] pairs_left;
  logic [47:0]   sh;
  logic [2:0]    left;

  function automatic logic [7:0] hdr_byte(input logic [5:0] i);
    logic [31:0] word;
    int off;
    word = 32'd0;
    off  = 0;
    if (i == 6'd0) word = 32'd66;
    else if (i == 6'd1) word = 32'd77;
    else if (i >= 6'd2 && i <= 6'd5) begin word = 32'(FSIZE); off = int'(i) - 2; end
    else if (i >= 6'd10 && i <= 6'd13) begin word = 32'd54; off = int'(i) - 10; end
    else if (i >= 6'd14 && i <= 6'd17) begin word = 32'd40; off = int'(i) - 14; end
    else if (i >= 6'd18 && i <= 6'd21) begin word = 32'(IMG_W); off = int'(i) - 18; end
    else if (i >= 6'd22 && i <= 6'd25) begin word = 32'(IMG_H); off = int'(i) - 22; end
    else if (i >= 6'd26 && i <= 6'd27) begin word = 32'd1; off = int'(i) - 26; end
    else if (i >= 6'd28 && i <= 6'd29) begin word = 32'd24; off = int'(i) - 28; end
    return 8'(word >> (8 * off));
  endfunction

  assign out_valid  = (st == S_HDR) || (st == S_PIX && left != 3'd0);
  assign out_byte   = (st == S_HDR) ? hdr_byte(hdr_idx) : sh[7:0];
  assign out_last   = (st == S_PIX) && (left == 3'd1) && (pairs_left == '0);
  assign pair_ready = (st == S_PIX) && (left == 3'd0) && (pairs_left != '0);
  assign file_done  = (st == S_DONE);

  wire fire = out_valid && out_ready;
  wire take = pair_valid && pair_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_HDR;
      hdr_idx    <= 6'd0;
      pairs_left <= PW'(NPAIRS);
      sh         <= 48'd0;
      left       <= 3'd0;
    end else begin
      case (st)
        S_HDR: if (fire) begin
          if (hdr_idx == 6'd53) st <= S_PIX;
          else hdr_idx <= hdr_idx + 6'd1;
        end
        S_PIX: begin
          if (take) begin
            sh         <= pair_data;
            left       <= 3'd6;
            pairs_left <= pairs_left - PW'(1);
          end else if (fire) begin
            sh   <= sh >> 8;
            left <= left - 3'd1;
            if (out_last) st <= S_DONE;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/bmp_stream_fmt_chk.sv
module bmp_stream_fmt_chk #(
  parameter int IMG_W = 768,
  parameter int IMG_H = 512
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pair_valid,
  input logic       pair_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_last,
  input logic       file_done
);
  localparam int FTOT = 54 + 3 * IMG_W * IMG_H;
  logic [31:0] nbytes;

  always_ff @(posedge clk) begin
    if (!rst_n) nbytes <= 32'd0;
    else if (out_valid && out_ready) nbytes <= nbytes + 32'd1;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready) |=> !pair_ready);

  assert_closed_in_header_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nbytes < 32'd54) |-> !pair_ready);

  assert_last_position_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (nbytes == 32'(FTOT - 1)));

  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> file_done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    file_done |-> (!out_valid && !pair_ready));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    file_done |=> file_done);
endmodule

bind bmp_stream_fmt bmp_stream_fmt_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_ready(pair_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .out_last(out_last), .file_done(file_done)
);

// File: tb/test_bmp_stream_fmt.sv
`timescale 1ns/1ps
module test_bmp_stream_fmt;
  localparam int W = 8;
  localparam int H = 34;
  localparam int NP = W * H / 2;
  localparam int FTOT = 54 + 3 * W * H;   // 870 = 0x366

  localparam int NH = 23;
  localparam logic [15:0] HTAB [NH] = '{
    {8'd0, 8'd66}, {8'd1, 8'd77}, {8'd2, 8'h66}, {8'd3, 8'h03}, {8'd4, 8'd0},
    {8'd5, 8'd0}, {8'd6, 8'd0}, {8'd9, 8'd0}, {8'd10, 8'd54}, {8'd11, 8'd0},
    {8'd14, 8'd40}, {8'd17, 8'd0}, {8'd18, 8'd8}, {8'd19, 8'd0}, {8'd22, 8'd34},
    {8'd23, 8'd0}, {8'd26, 8'd1}, {8'd27, 8'd0}, {8'd28, 8'd24}, {8'd29, 8'd0},
    {8'd30, 8'd0}, {8'd40, 8'd0}, {8'd53, 8'd0}};

  logic clk = 1'b0, rst_n = 1'b0, pair_valid = 1'b0, out_ready = 1'b0;
  logic [47:0] pair_data = 48'd0;
  logic pair_ready, out_valid, out_last, file_done;
  logic [7:0] out_byte;

  bmp_stream_fmt #(.IMG_W(W), .IMG_H(H)) i_bmp_stream_fmt (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_data(pair_data),
    .pair_ready(pair_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last), .file_done(file_done));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] cap [FTOT + 8];
  int n = 0, nlast = 0, lastidx = -1, acc = 0, since = 0, gapbad = 0, early = 0;
  int stallbad = 0, stalls = 0;
  logic stall_q = 1'b0;
  logic [7:0] stall_b = 8'd0;
  logic mon_en = 1'b0;

  function automatic logic [7:0] pat(int k, int j);
    return 8'((k * 6 + j) * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst_n && mon_en) begin
      if (stall_q) begin
        stalls++;
        if (!out_valid || out_byte != stall_b) stallbad++;
      end
      stall_q = out_valid && !out_ready;
      stall_b = out_byte;
      if (pair_ready && n < 54) early++;
      if (pair_valid && pair_ready) begin
        if (acc > 0 && since != 6) gapbad++;
        acc++;
        since = 0;
      end
      if (out_valid && out_ready) begin
        if (n < FTOT + 8) cap[n] = out_byte;
        if (out_last) begin nlast++; lastidx = n; end
        if (n >= 54) since++;
        n++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int cyc;
    int pixbad;
    int n_hold;
    repeat (3) @(negedge clk);
    chk(pair_ready == 1'b0, "R10 pair_ready in reset", int'(pair_ready), 0);
    chk(file_done == 1'b0, "R10 file_done in reset", int'(file_done), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    #1;
    chk(out_valid == 1'b1 && out_byte == 8'd66, "R10 first byte after reset", int'(out_byte), 66);

    fork
      begin
        for (int k = 0; k < NP; k++) begin
          if (k % 3 == 1) begin pair_valid = 1'b0; @(negedge clk); end
          for (int j = 0; j < 6; j++) pair_data[8*j +: 8] = pat(k, j);
          pair_valid = 1'b1;
          forever begin
            @(posedge clk);
            if (pair_ready) break;
          end
          @(negedge clk);
          pair_valid = 1'b0;
        end
      end
      begin
        cyc = 0;
        while (!file_done) begin
          out_ready = (cyc % 5 != 2) && (cyc % 11 != 7);
          cyc++;
          @(negedge clk);
        end
      end
    join

    for (int i = 0; i < NH; i++)
      chk(cap[HTAB[i][15:8]] == HTAB[i][7:0], "R1 R2 R3 header byte",
          int'(cap[HTAB[i][15:8]]), int'(HTAB[i][7:0]));
    chk(early == 0, "R4 pair_ready during header", early, 0);
    pixbad = 0;
    for (int k = 0; k < NP; k++)
      for (int j = 0; j < 6; j++)
        if (cap[54 + 6*k + j] != pat(k, j)) pixbad++;
    chk(pixbad == 0, "R5 pixel byte order mismatches", pixbad, 0);
    chk(acc == NP, "R5 pairs accepted", acc, NP);
    chk(gapbad == 0, "R6 bytes between accepts not six", gapbad, 0);
    chk(stallbad == 0 && stalls > 0, "R7 stall stability errors", stallbad, 0);
    chk(nlast == 1, "R8 last flag count", nlast, 1);
    chk(lastidx == FTOT - 1, "R8 last flag index", lastidx, FTOT - 1);
    chk(n == FTOT, "R9 total bytes", n, FTOT);

    n_hold = n;
    pair_valid = 1'b1;
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(file_done == 1'b1, "R9 file_done held", int'(file_done), 1);
    chk(out_valid == 1'b0 && pair_ready == 1'b0, "R9 quiet after done",
        int'(out_valid) + int'(pair_ready), 0);
    chk(n == n_hold, "R9 no bytes after done", n, n_hold);
    pair_valid = 1'b0;

    mon_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(file_done == 1'b0, "R10 file_done cleared by reset", int'(file_done), 0);
    rst_n = 1'b1;
    #1;
    chk(out_byte == 8'd66, "R10 header restarts byte 0", int'(out_byte), 66);
    @(negedge clk);
    chk(out_byte == 8'd77, "R10 header restarts byte 1", int'(out_byte), 77);
    finish_up();
  end
endmodule